// File: doc/BRIEF.md
# Fault Event Interrupt Controller

This block collects fault status for an address-translation unit and decides when one message-signalled interrupt goes out. Three status flags feed it. The first is a primary pending-fault flag, which a bank of fault recording slots sets through a record strobe; hardware clears it once every slot's fault bit reads clear. The second is an invalidation queue error flag and the third is an invalidation completion timeout flag. Software clears those two by writing 1 to them.

The block raises an interrupt condition only when a flag is set while no flag was already set. That condition sets a pending bit. The pending bit is held while the mask bit is set, and it is also held while the message port applies backpressure. It is dropped when the message is accepted. It is also dropped when every status flag becomes clear before a message has been issued.

A software register port is word-indexed by `reg_sel`, and reads are combinational:
- Word 0 is status: bit 0 is primary pending, bit 1 is queue error, bit 2 is timeout.
- Word 1 is control: bit 31 is the mask and bit 30 is pending.
- Word 2 is message data.
- Word 3 is the message address.

Writes take effect at the next clock edge.

The outgoing message uses a valid/ready handshake. Once `msg_valid` rises, it stays high with `msg_addr` and `msg_data` frozen until `msg_ready` is seen high at a clock edge. Only one message is in flight at a time. A new condition that arrives while a message is in flight is remembered, and a second message follows once the first is accepted.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, status reads 0, control reads 0x8000_0000 (mask set, not pending), data and address read 0, and `msg_valid` is low.
- R2: Control bit 31 is the mask and is writable. Bit 30 is pending and ignores writes. Bits 29:0 read 0.
- R3: The data word keeps bits 15:0 on write and reads bits 31:16 as 0. The address word is 32-bit read/write. A message carries the address and data values held at the moment it is issued.
- R4: Pending is set when any status flag is set while all three flags were clear. Setting a flag while another is already set raises no new condition.
- R5: While the mask bit is 1, `msg_valid` does not rise, and pending stays set.
- R6: When pending is set, the mask is 0 and no message is in flight, `msg_valid` rises at the next clock edge.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. Pending reads 0 after the accepting edge unless a new condition arrived during the flight.
- R8: If pending is set, no message is in flight, and all status flags become clear, pending drops and no message is sent.
- R9: A record strobe sets primary pending (status bit 0). Hardware clears it when all fault bits are 0. Software writes to bit 0 have no effect.
- R10: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R11: A new condition that occurs while a message is in flight produces a second message after the first is accepted, unless all flags are cleared before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_bits | input | NUM_SLOTS | Fault bit of each recording slot |
| flt_rec_stb | input | 1 | One-cycle strobe: a fault was recorded |
| iq_err_evt | input | 1 | Invalidation queue error detected |
| inv_tmo_evt | input | 1 | Invalidation completion timeout detected |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| msg_valid | output | 1 | Interrupt message request |
| msg_ready | input | 1 | Message port accepts at this edge |
| msg_addr | output | MADDR_W | Message address |
| msg_data | output | DATA_W | Message data |

## Verification
The bench sets a flag while another is already set. A design that treats every flag edge as a condition would then send duplicate messages. It clears the mask while backpressure is applied, and rewrites the data register during the stall. A launcher that re-reads its sources would then change `msg_data` mid-flight. It drains the flags under the mask and then unmasks, which must produce no message. It also raises a condition during a message flight, which exposes a design that loses the second message. A random phase mixes events, writes and ready patterns against a behavioural model every cycle.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_ADDR   = 2'd3
  } reg_sel_e;

  localparam int REG_W    = 32;
  localparam int MASK_POS = 31;
  localparam int PEND_POS = 30;
  localparam int ST_PPF   = 0;
  localparam int ST_IQE   = 1;
  localparam int ST_ICT   = 2;

  typedef struct packed {
    logic ict;
    logic iqe;
    logic ppf;
  } flt_status_t;
endpackage

// File: rtl/flt_status_unit.sv
module flt_status_unit
  import fault_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] flt_bits,
  input  logic                 rec_stb,
  input  logic                 iqe_evt,
  input  logic                 ict_evt,
  input  logic                 clr_iqe,
  input  logic                 clr_ict,
  output flt_status_t          status_q,
  output logic                 all_clear_nxt,
  output logic                 new_cond
);
  flt_status_t status_d;
  logic        any_slot;
  logic        any_set_q;

  assign any_slot  = |flt_bits;
  assign any_set_q = status_q.ppf | status_q.iqe | status_q.ict;

  always_comb begin
    status_d.ppf = rec_stb | (status_q.ppf & any_slot);
    status_d.iqe = iqe_evt | (status_q.iqe & ~clr_iqe);
    status_d.ict = ict_evt | (status_q.ict & ~clr_ict);
  end

  assign all_clear_nxt = ~(status_d.ppf | status_d.iqe | status_d.ict);
  assign new_cond      = ~any_set_q & (rec_stb | iqe_evt | ict_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/flt_cfg_regs.sv
module flt_cfg_regs
  import fault_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  flt_status_t        status_q,
  input  logic               pending_q,
  output logic               mask_q,
  output logic [DATA_W-1:0]  data_q,
  output logic [MADDR_W-1:0] addr_q,
  output logic               clr_iqe,
  output logic               clr_ict,
  output logic [REG_W-1:0]   reg_rdata
);
  localparam int STW = $bits(flt_status_t);
  reg_sel_e sel;
  logic     wr_status, wr_ctrl, wr_data, wr_addr;

  assign sel       = reg_sel_e'(reg_sel);
  assign wr_status = reg_wr && (sel == SEL_STATUS);
  assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
  assign wr_data   = reg_wr && (sel == SEL_DATA);
  assign wr_addr   = reg_wr && (sel == SEL_ADDR);
  assign clr_iqe   = wr_status & reg_wdata[ST_IQE];
  assign clr_ict   = wr_status & reg_wdata[ST_ICT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (wr_ctrl) mask_q <= reg_wdata[MASK_POS];
      if (wr_data) data_q <= reg_wdata[DATA_W-1:0];
      if (wr_addr) addr_q <= reg_wdata[MADDR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: reg_rdata[STW-1:0]      = status_q;
      SEL_CTRL: begin
        reg_rdata[MASK_POS] = mask_q;
        reg_rdata[PEND_POS] = pending_q;
      end
      SEL_DATA:   reg_rdata[DATA_W-1:0]  = data_q;
      SEL_ADDR:   reg_rdata[MADDR_W-1:0] = addr_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flt_pend_ctrl.sv
module flt_pend_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic new_cond,
  input  logic all_clear_nxt,
  input  logic mask_q,
  input  logic in_flight,
  input  logic accept,
  output logic pending_q,
  output logic launch
);
  logic rearm_q;
  logic drop;

  assign drop   = pending_q & ~in_flight & all_clear_nxt & ~new_cond;
  assign launch = pending_q & ~mask_q & ~in_flight & ~drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      rearm_q   <= 1'b0;
    end else if (accept) begin
      pending_q <= new_cond | (rearm_q & ~all_clear_nxt);
      rearm_q   <= 1'b0;
    end else if (in_flight) begin
      rearm_q   <= new_cond | (rearm_q & ~all_clear_nxt);
    end else if (new_cond) begin
      pending_q <= 1'b1;
    end else if (drop) begin
      pending_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flt_msg_launch.sv
module flt_msg_launch #(
  parameter int DATA_W  = 16,
  parameter int MADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [DATA_W-1:0]  data_q,
  input  logic [MADDR_W-1:0] addr_q,
  input  logic               msg_ready,
  output logic               msg_valid,
  output logic [MADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0]  msg_data,
  output logic               accept
);
  assign accept = msg_valid & msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (launch) begin
      msg_valid <= 1'b1;
      msg_addr  <= addr_q;
      msg_data  <= data_q;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 16,
  parameter int MADDR_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] flt_bits,
  input  logic                 flt_rec_stb,
  input  logic                 iq_err_evt,
  input  logic                 inv_tmo_evt,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [MADDR_W-1:0]   msg_addr,
  output logic [DATA_W-1:0]    msg_data
);
  flt_status_t        status_q;
  logic [2:0]         status_bits;
  logic               all_clear_nxt, new_cond;
  logic               clr_iqe, clr_ict;
  logic               mask_q, pending_q, launch, accept;
  logic [DATA_W-1:0]  data_q;
  logic [MADDR_W-1:0] addr_q;

  assign status_bits = status_q;

  flt_status_unit #(.NUM_SLOTS(NUM_SLOTS)) u_status (
    .clk(clk), .rst_n(rst_n), .flt_bits(flt_bits), .rec_stb(flt_rec_stb),
    .iqe_evt(iq_err_evt), .ict_evt(inv_tmo_evt), .clr_iqe(clr_iqe),
    .clr_ict(clr_ict), .status_q(status_q), .all_clear_nxt(all_clear_nxt),
    .new_cond(new_cond)
  );

  flt_cfg_regs #(.DATA_W(DATA_W), .MADDR_W(MADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status_q(status_q), .pending_q(pending_q),
    .mask_q(mask_q), .data_q(data_q), .addr_q(addr_q), .clr_iqe(clr_iqe),
    .clr_ict(clr_ict), .reg_rdata(reg_rdata)
  );

  flt_pend_ctrl u_pend (
    .clk(clk), .rst_n(rst_n), .new_cond(new_cond),
    .all_clear_nxt(all_clear_nxt), .mask_q(mask_q), .in_flight(msg_valid),
    .accept(accept), .pending_q(pending_q), .launch(launch)
  );

  flt_msg_launch #(.DATA_W(DATA_W), .MADDR_W(MADDR_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .data_q(data_q),
    .addr_q(addr_q), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .accept(accept)
  );
endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 16,
  parameter int MADDR_W   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [MADDR_W-1:0]   msg_addr,
  input logic [DATA_W-1:0]    msg_data,
  input logic                 mask,
  input logic                 pending,
  input logic [2:0]           status,
  input logic [NUM_SLOTS-1:0] flt_bits,
  input logic                 rec_stb,
  input logic                 iqe_evt,
  input logic                 ict_evt
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  assert_one_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && mask |=> !msg_valid);

  assert_valid_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> pending);

  assert_ppf_autoclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && (flt_bits == '0) && !rec_stb |=> !status[0]);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pending && !msg_valid && (status == 3'b000) && !rec_stb && !iqe_evt && !ict_evt
    |=> !pending);
endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .MADDR_W(MADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .mask(mask_q), .pending(pending_q),
  .status(status_bits), .flt_bits(flt_bits), .rec_stb(flt_rec_stb),
  .iqe_evt(iq_err_evt), .ict_evt(inv_tmo_evt)
);

// File: tb/fault_irq_ctrl_tb.sv
module fault_irq_ctrl_tb;
  localparam int NS = 8;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] flt_bits = '0;
  logic          flt_rec_stb = 1'b0, iq_err_evt = 1'b0, inv_tmo_evt = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          msg_valid, msg_ready = 1'b0;
  logic [31:0]   msg_addr;
  logic [15:0]   msg_data;

  int tests = 0, fails = 0, accepts = 0;

  // behavioural reference state
  bit m_ppf, m_iqe, m_ict, m_mask, m_pend, m_valid, m_rearm;
  bit [15:0] m_data, m_mdata;
  bit [31:0] m_addr, m_maddr;

  fault_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .flt_bits(flt_bits), .flt_rec_stb(flt_rec_stb),
    .iq_err_evt(iq_err_evt), .inv_tmo_evt(inv_tmo_evt), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return {29'd0, m_ict, m_iqe, m_ppf};
      2'd1: return {m_mask, m_pend, 30'd0};
      2'd2: return {16'd0, m_data};
      default: return m_addr;
    endcase
  endfunction

  // reference update on each edge, then compare shortly after
  always @(posedge clk) begin
    bit n_ppf, n_iqe, n_ict, cond, allclr, acc, drop, launch, w1c;
    if (!rst_n) begin
      m_ppf = 0; m_iqe = 0; m_ict = 0; m_mask = 1; m_pend = 0; m_valid = 0;
      m_rearm = 0; m_data = 0; m_addr = 0; m_mdata = 0; m_maddr = 0;
    end else begin
      acc    = m_valid && msg_ready;
      w1c    = reg_wr && reg_sel == 2'd0;
      n_ppf  = flt_rec_stb || (m_ppf && flt_bits != 0);
      n_iqe  = iq_err_evt || (m_iqe && !(w1c && reg_wdata[1]));
      n_ict  = inv_tmo_evt || (m_ict && !(w1c && reg_wdata[2]));
      cond   = !(m_ppf || m_iqe || m_ict) && (flt_rec_stb || iq_err_evt || inv_tmo_evt);
      allclr = !(n_ppf || n_iqe || n_ict);
      drop   = m_pend && !m_valid && allclr && !cond;
      launch = m_pend && !m_mask && !m_valid && !drop;
      if (acc) accepts++;
      if (launch) begin m_maddr = m_addr; m_mdata = m_data; end
      if (acc) begin
        m_pend = cond || (m_rearm && !allclr); m_rearm = 0;
      end else if (m_valid) m_rearm = cond || (m_rearm && !allclr);
      else if (cond) m_pend = 1;
      else if (drop) m_pend = 0;
      m_valid = launch ? 1'b1 : (acc ? 1'b0 : m_valid);
      m_ppf = n_ppf; m_iqe = n_iqe; m_ict = n_ict;
      if (reg_wr && reg_sel == 2'd1) m_mask = reg_wdata[31];
      if (reg_wr && reg_sel == 2'd2) m_data = reg_wdata[15:0];
      if (reg_wr && reg_sel == 2'd3) m_addr = reg_wdata;
    end
    #1;
    if (rst_n) begin
      check(msg_valid === m_valid, "R6", {31'd0, msg_valid}, {31'd0, m_valid});
      if (m_valid) begin
        check(msg_addr === m_maddr, "R7", msg_addr, m_maddr);
        check(msg_data === m_mdata, "R3", {16'd0, msg_data}, {16'd0, m_mdata});
      end
      case (reg_sel)
        2'd0: check(reg_rdata === model_read(0), "R9", reg_rdata, model_read(0));
        2'd1: check(reg_rdata === model_read(1), "R2", reg_rdata, model_read(1));
        default: check(reg_rdata === model_read(reg_sel), "R3", reg_rdata,
                       model_read(reg_sel));
      endcase
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk); reg_sel = s;
    #1 check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic pulse(input int kind);
    @(negedge clk);
    case (kind)
      0: flt_rec_stb = 1;
      1: iq_err_evt = 1;
      default: inv_tmo_evt = 1;
    endcase
    @(negedge clk); flt_rec_stb = 0; iq_err_evt = 0; inv_tmo_evt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(0, 32'h0, "R1"); rd_chk(1, 32'h8000_0000, "R1");
    rd_chk(2, 32'h0, "R1"); rd_chk(3, 32'h0, "R1");
    check(msg_valid === 1'b0, "R1", {31'd0, msg_valid}, 32'd0);
    // R3 / R2 register formats
    wr(2, 32'hABCD_1234); rd_chk(2, 32'h0000_1234, "R3");
    wr(3, 32'hFEE0_0010); rd_chk(3, 32'hFEE0_0010, "R3");
    wr(1, 32'hFFFF_FFFF); rd_chk(1, 32'h8000_0000, "R2");
    // R4 first flag raises pending; R5 masked
    flt_bits = 8'h01; pulse(0); idle(4);
    rd_chk(1, 32'hC000_0000, "R4");
    check(msg_valid === 1'b0, "R5", {31'd0, msg_valid}, 32'd0);
    pulse(1); idle(2);
    rd_chk(0, 32'h3, "R4");
    base = accepts;
    // R6 unmask under backpressure, R7 hold while data reg changes
    msg_ready = 0; wr(1, 32'h0); idle(2);
    check(msg_valid === 1'b1, "R6", {31'd0, msg_valid}, 32'd1);
    wr(2, 32'h5555); idle(2);
    check(msg_data === 16'h1234, "R7", {16'd0, msg_data}, 32'h1234);
    @(negedge clk); msg_ready = 1; @(negedge clk); msg_ready = 0;
    rd_chk(1, 32'h0, "R7");
    check(accepts == base + 1, "R7", accepts, base + 1);
    // R9 ppf ignores software, cleared by hardware
    wr(0, 32'h1); rd_chk(0, 32'h3, "R9");
    flt_bits = 0; idle(1); rd_chk(0, 32'h2, "R9");
    // R10 write-1-to-clear
    wr(0, 32'h0); rd_chk(0, 32'h2, "R10");
    wr(0, 32'h2); rd_chk(0, 32'h0, "R10");
    // R6 message with port ready
    msg_ready = 1; base = accepts; pulse(2); idle(4);
    check(accepts == base + 1, "R6", accepts, base + 1);
    rd_chk(0, 32'h4, "R10");
    wr(0, 32'h4); rd_chk(0, 32'h0, "R10");
    // R8 flags drained under mask
    wr(1, 32'h8000_0000); base = accepts;
    flt_bits = 8'h02; pulse(0); idle(2); rd_chk(1, 32'hC000_0000, "R8");
    flt_bits = 0; idle(2); rd_chk(1, 32'h8000_0000, "R8");
    wr(1, 32'h0); idle(4);
    check(accepts == base, "R8", accepts, base);
    // R11 condition during flight
    msg_ready = 0; base = accepts; pulse(2); idle(2);
    wr(0, 32'h4); pulse(1); idle(2);
    @(negedge clk); msg_ready = 1; idle(6);
    check(accepts == base + 2, "R11", accepts, base + 2);
    rd_chk(1, 32'h0, "R11");
    // random phase, compared to the model every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      msg_ready   = $urandom_range(0, 1);
      flt_rec_stb = ($urandom_range(0, 15) == 0);
      iq_err_evt  = ($urandom_range(0, 19) == 0);
      inv_tmo_evt = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) flt_bits = $urandom_range(0, 3);
      reg_wr    = ($urandom_range(0, 5) == 0);
      reg_sel   = $urandom_range(0, 3);
      reg_wdata = $urandom;
    end
    @(negedge clk);
    reg_wr = 0; flt_rec_stb = 0; iq_err_evt = 0; inv_tmo_evt = 0;
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule